// File: doc/BRIEF.md
# Exception Context Save Controller

This block runs when an exception is taken. It decides where the processor's working context goes and then stores it. Every exception pushes the status word and the return PC onto the memory stack, one 32-bit word per cycle, with a pre-decrement of the stack pointer by 4 before each write. An ordinary maskable interrupt taken while bank saving is enabled also copies the general context in one wide write into the next free hardware register bank. That context is nineteen words (R0 to R14, GBR, MACH, MACL, PR) together with the vector number. The block then updates the interrupt mask. Non-maskable interrupts, debug-break interrupts, address errors, bank errors and instruction traps never use a bank.

Once all banks are occupied, the overflow-exception enable picks what happens to a bank-eligible interrupt. With the enable clear, the nineteen context words are pushed to the stack after the PC. With it set, the block signals a bank-overflow exception in place of the save. A one-cycle completion pulse tells the fetch logic that it may read the handler address. The vector fetch and the restore of banks lie outside this block.

Top module: `ctx_save_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_we`, `bank_we`, `save_done`, `ovf_exc`, `mask_we`, `bank_full`, `bank_cnt` and `sp_out` are all 0.
- R2: For every exception kind, the first pushed word is `sr_in` at address `sp_in-4` and the second is `pc_in` at `sp_in-8`. In the done cycle `sp_out` equals `sp_in` minus 4 times the number of pushed words.
- R3: Pushes start in the cycle after `start` is sampled. There is one word per cycle, each address 4 below the previous one.
- R4: For kind 0 (maskable interrupt) with `bank_en`=1 and a free bank, the done cycle asserts `bank_we`. In that cycle `bank_idx` equals the current `bank_cnt` and `bank_wdata` = {`vec_num`, `ctx_in`}, where `ctx_in` word k (bits 32k+31:32k) holds R0..R14, GBR, MACH, MACL, PR for k = 0..18. `bank_cnt` then rises by 1.
- R5: Kinds 1 (NMI), 2 (debug break), 3 (address error), 4 (bank error) and 5 (trap) never write a bank, and neither does kind 0 with `bank_en`=0. In those cases exactly two words are pushed and `bank_cnt` is unchanged.
- R6: For kind 0 with `bank_en`=1, all banks full and `ovf_en`=0, the nineteen context words are pushed after the PC with word 0 first. No bank is written.
- R7: For kind 0 with `bank_en`=1, all banks full and `ovf_en`=1, `ovf_exc` pulses in the done cycle. Only the status word and PC are pushed, and neither `bank_we` nor `mask_we` is asserted.
- R8: Kinds 0, 1 and 2 assert `mask_we` with `mask_val` = `level` in the done cycle, except in the R7 case. Kinds 3, 4 and 5 never assert `mask_we`.
- R9: `save_done` is high for exactly one cycle, in the cycle after the last push. `busy` is high from the first push through the done cycle, and `start` is ignored while busy.
- R10: `bank_cnt` saturates at 15 and `bank_full` is 1 exactly when `bank_cnt` is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Exception entry request, sampled when idle |
| exc_kind | input | 3 | 0 interrupt, 1 NMI, 2 debug break, 3 address error, 4 bank error, 5 trap |
| level | input | 4 | Accepted interrupt priority level |
| vec_num | input | 8 | Vector number of the exception |
| bank_en | input | 1 | Bank saving enabled |
| ovf_en | input | 1 | Raise overflow exception when banks are full |
| sp_in | input | 32 | Stack pointer (R15) at entry |
| sr_in | input | 32 | Status word at entry |
| pc_in | input | 32 | Return PC |
| ctx_in | input | 608 | Context words R0..R14, GBR, MACH, MACL, PR, held stable while busy |
| busy | output | 1 | Save in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 32 | Stack write address |
| mem_wdata | output | 32 | Stack write data |
| sp_out | output | 32 | Updated stack pointer |
| bank_we | output | 1 | Bank write strobe |
| bank_idx | output | 4 | Bank being written |
| bank_wdata | output | 616 | Vector number above context words |
| bank_cnt | output | 4 | Number of occupied banks |
| bank_full | output | 1 | All banks occupied |
| mask_we | output | 1 | Interrupt mask update strobe |
| mask_val | output | 4 | New interrupt mask value |
| ovf_exc | output | 1 | Bank-overflow exception pulse |
| save_done | output | 1 | Save complete, handler fetch may begin |

## Verification
The hardest states to reach are the two full-bank outcomes: the stack spill and the overflow exception. Both depend on fifteen earlier bank saves that are never released. The stimulus first sweeps every exception kind against every `bank_en` and `ovf_en` combination while banks are still free. It then issues maskable interrupts until the count saturates, and repeats the full sweep against the full banks. One request in that final sweep holds `start` high for its whole run, which shows that a busy controller does not accept a new request.

// File: rtl/ctxsave_pkg.sv
package ctxsave_pkg;

    typedef enum logic [2:0] {
        EXC_IRQ     = 3'd0,
        EXC_NMI     = 3'd1,
        EXC_BRK     = 3'd2,
        EXC_ADDR    = 3'd3,
        EXC_BANKERR = 3'd4,
        EXC_TRAP    = 3'd5
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_FIN  = 2'd2
    } save_state_e;

    typedef struct packed {
        logic use_bank;
        logic spill;
        logic overflow;
        logic set_mask;
    } route_t;

    function automatic route_t route_of(input logic [2:0] kind, input logic bank_en,
                                        input logic full, input logic ovf_en);
        route_t r;
        logic is_irq;
        logic is_int;
        logic want;
        is_irq     = (kind == EXC_IRQ);
        is_int     = (kind == EXC_IRQ) || (kind == EXC_NMI) || (kind == EXC_BRK);
        want       = is_irq && bank_en;
        r.use_bank = want && !full;
        r.spill    = want && full && !ovf_en;
        r.overflow = want && full && ovf_en;
        r.set_mask = is_int && !r.overflow;
        return r;
    endfunction

endpackage

// File: rtl/ctxsave_route.sv
module ctxsave_route
    import ctxsave_pkg::*;
(
    input  logic [2:0] kind,
    input  logic       bank_en,
    input  logic       full,
    input  logic       ovf_en,
    output route_t     route
);
    always_comb route = route_of(kind, bank_en, full, ovf_en);
endmodule

// File: rtl/ctxsave_bank_counter.sv
module ctxsave_bank_counter #(
    parameter int unsigned NBANK = 15,
    localparam int unsigned CW   = $clog2(NBANK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          full
);
    assign full = (cnt == CW'(NBANK));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !full) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctxsave_push_seq.sv
module ctxsave_push_seq #(
    parameter int unsigned NCTX = 19,
    localparam int unsigned NW  = NCTX + 2,
    localparam int unsigned IW  = $clog2(NW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [31:0]       sp_in,
    input  logic [31:0]       sr_in,
    input  logic [31:0]       pc_in,
    input  logic [NCTX*32-1:0] ctx_in,
    output logic [IW-1:0]     idx,
    output logic [31:0]       sp_q,
    output logic [31:0]       addr,
    output logic [31:0]       wdata
);
    logic [31:0] sr_q;
    logic [31:0] pc_q;
    logic [31:0] words [NW];

    assign words[0] = sr_q;
    assign words[1] = pc_q;
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx_word
        assign words[g+2] = ctx_in[g*32 +: 32];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            sp_q <= '0;
            sr_q <= '0;
            pc_q <= '0;
        end else if (load) begin
            idx  <= '0;
            sp_q <= sp_in;
            sr_q <= sr_in;
            pc_q <= pc_in;
        end else if (step) begin
            idx  <= idx + 1'b1;
            sp_q <= sp_q - 32'd4;
        end
    end

    assign addr = sp_q - 32'd4;

    always_comb begin
        wdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (idx == IW'(i)) wdata = words[i];
        end
    end
endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl
    import ctxsave_pkg::*;
#(
    parameter int unsigned NBANK = 15,
    parameter int unsigned NCTX  = 19,
    parameter int unsigned VW    = 8,
    localparam int unsigned CW   = $clog2(NBANK + 1),
    localparam int unsigned IW   = $clog2(NCTX + 3)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [2:0]            exc_kind,
    input  logic [3:0]            level,
    input  logic [VW-1:0]         vec_num,
    input  logic                  bank_en,
    input  logic                  ovf_en,
    input  logic [31:0]           sp_in,
    input  logic [31:0]           sr_in,
    input  logic [31:0]           pc_in,
    input  logic [NCTX*32-1:0]    ctx_in,
    output logic                  busy,
    output logic                  mem_we,
    output logic [31:0]           mem_addr,
    output logic [31:0]           mem_wdata,
    output logic [31:0]           sp_out,
    output logic                  bank_we,
    output logic [CW-1:0]         bank_idx,
    output logic [VW+NCTX*32-1:0] bank_wdata,
    output logic [CW-1:0]         bank_cnt,
    output logic                  bank_full,
    output logic                  mask_we,
    output logic [3:0]            mask_val,
    output logic                  ovf_exc,
    output logic                  save_done
);
    save_state_e    state;
    route_t         route_now;
    route_t         route_q;
    logic [VW-1:0]  vec_q;
    logic [3:0]     lvl_q;
    logic [IW-1:0]  last_q;
    logic [IW-1:0]  idx;
    logic           accept;
    logic           in_push;
    logic           in_fin;

    assign accept  = (state == ST_IDLE) && start;
    assign in_push = (state == ST_PUSH);
    assign in_fin  = (state == ST_FIN);

    ctxsave_route u_route (
        .kind    (exc_kind),
        .bank_en (bank_en),
        .full    (bank_full),
        .ovf_en  (ovf_en),
        .route   (route_now)
    );

    ctxsave_bank_counter #(.NBANK(NBANK)) u_banks (
        .clk  (clk),
        .rst  (rst),
        .inc  (bank_we),
        .cnt  (bank_cnt),
        .full (bank_full)
    );

    ctxsave_push_seq #(.NCTX(NCTX)) u_push (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (in_push),
        .sp_in  (sp_in),
        .sr_in  (sr_in),
        .pc_in  (pc_in),
        .ctx_in (ctx_in),
        .idx    (idx),
        .sp_q   (sp_out),
        .addr   (mem_addr),
        .wdata  (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            route_q <= '0;
            vec_q   <= '0;
            lvl_q   <= '0;
            last_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_PUSH;
                    route_q <= route_now;
                    vec_q   <= vec_num;
                    lvl_q   <= level;
                    last_q  <= route_now.spill ? IW'(NCTX + 1) : IW'(1);
                end
                ST_PUSH: if (idx == last_q) state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign mem_we     = in_push;
    assign save_done  = in_fin;
    assign bank_we    = in_fin && route_q.use_bank;
    assign bank_idx   = bank_cnt;
    assign bank_wdata = {vec_q, ctx_in};
    assign mask_we    = in_fin && route_q.set_mask;
    assign mask_val   = lvl_q;
    assign ovf_exc    = in_fin && route_q.overflow;
endmodule

// File: rtl/ctx_save_ctrl_chk.sv
module ctx_save_ctrl_chk #(
    parameter int unsigned NBANK = 15,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          mem_we,
    input logic [31:0]   mem_addr,
    input logic          bank_we,
    input logic [CW-1:0] bank_cnt,
    input logic          bank_full,
    input logic          mask_we,
    input logic          ovf_exc,
    input logic          save_done
);
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 32'd4));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        save_done |=> !save_done);

    p_done_after_push_r9: assert property (@(posedge clk) disable iff (rst)
        save_done |-> $past(mem_we));

    p_push_busy_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_ovf_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_exc |-> (!bank_we && !mask_we && save_done));

    p_bank_step_r4: assert property (@(posedge clk) disable iff (rst)
        bank_we |=> (bank_cnt == $past(bank_cnt) + 1'b1));

    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bank_we |=> $stable(bank_cnt));

    p_no_write_full_r6: assert property (@(posedge clk) disable iff (rst)
        bank_full |-> !bank_we);

    p_full_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        bank_full |=> (bank_full && bank_cnt == CW'(NBANK)));
endmodule

bind ctx_save_ctrl ctx_save_ctrl_chk #(.NBANK(NBANK), .CW(CW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .bank_we   (bank_we),
    .bank_cnt  (bank_cnt),
    .bank_full (bank_full),
    .mask_we   (mask_we),
    .ovf_exc   (ovf_exc),
    .save_done (save_done)
);

// File: tb/ctx_save_ctrl_tb_top.sv
module ctx_save_ctrl_tb_top;
    localparam int NB   = 15;
    localparam int NCTX = 19;
    localparam int VW   = 8;
    localparam int CW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] exc_kind = '0;
    logic [3:0] level = '0;
    logic [VW-1:0] vec_num = '0;
    logic bank_en = 1'b0;
    logic ovf_en = 1'b0;
    logic [31:0] sp_in = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] pc_in = '0;
    logic [NCTX*32-1:0] ctx_in = '0;
    logic busy, mem_we, bank_we, bank_full, mask_we, ovf_exc, save_done;
    logic [31:0] mem_addr, mem_wdata, sp_out;
    logic [CW-1:0] bank_idx, bank_cnt;
    logic [VW+NCTX*32-1:0] bank_wdata;
    logic [3:0] mask_val;

    int n_run = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    int seed = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ctx_save_ctrl dut_i (
        .clk(clk), .rst(rst), .start(start), .exc_kind(exc_kind), .level(level),
        .vec_num(vec_num), .bank_en(bank_en), .ovf_en(ovf_en), .sp_in(sp_in),
        .sr_in(sr_in), .pc_in(pc_in), .ctx_in(ctx_in), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_out(sp_out), .bank_we(bank_we),
        .bank_idx(bank_idx), .bank_wdata(bank_wdata), .bank_cnt(bank_cnt),
        .bank_full(bank_full), .mask_we(mask_we), .mask_val(mask_val),
        .ovf_exc(ovf_exc), .save_done(save_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        if (w == 0) return sr_in;
        if (w == 1) return pc_in;
        return ctx_in[(w-2)*32 +: 32];
    endfunction

    task automatic run_exc(input int kind, input int lvl, input int vec,
                           input bit ben, input bit oen, input bit hold);
        bit is_irq, is_int, want, full, use_bank, spill, ovf, setm;
        int n;
        logic [31:0] sp0;
        is_irq   = (kind == 0);
        is_int   = (kind <= 2);
        want     = is_irq && ben;
        full     = (exp_cnt == NB);
        use_bank = want && !full;
        spill    = want && full && !oen;
        ovf      = want && full && oen;
        setm     = is_int && !ovf;
        n        = spill ? NCTX + 2 : 2;
        seed++;
        sp0 = 32'h0010_0000 + 32'(seed) * 32'h400;
        exc_kind = 3'(kind); level = 4'(lvl); vec_num = 8'(vec);
        bank_en = ben; ovf_en = oen; sp_in = sp0;
        sr_in = 32'h5A00_0000 ^ 32'(seed);
        pc_in = 32'h0800_0000 + 32'(seed) * 32'h10;
        for (int k = 0; k < NCTX; k++) ctx_in[k*32 +: 32] = 32'hA500_0000 ^ (32'(seed) << 8) ^ 32'(k);
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        for (int w = 0; w < n; w++) begin
            chk(mem_we == 1'b1, "R3 push strobe", 64'(mem_we), 64'd1);
            chk(mem_addr == sp0 - 32'(4 * (w + 1)), (w < 2) ? "R2 push addr" : "R6 spill addr",
                64'(mem_addr), 64'(sp0 - 32'(4 * (w + 1))));
            chk(mem_wdata == exp_word(w), (w < 2) ? "R2 push data" : "R6 spill data",
                64'(mem_wdata), 64'(exp_word(w)));
            chk(save_done == 1'b0 && busy == 1'b1, "R9 busy while pushing", 64'(save_done), 64'd0);
            @(negedge clk);
        end
        start = 1'b0;
        chk(mem_we == 1'b0, "R5 push count", 64'(mem_we), 64'd0);
        chk(save_done == 1'b1, "R9 done pulse", 64'(save_done), 64'd1);
        chk(bank_we == use_bank, use_bank ? "R4 bank write" : "R5 no bank write", 64'(bank_we), 64'(use_bank));
        if (use_bank) begin
            chk(bank_idx == CW'(exp_cnt), "R4 bank index", 64'(bank_idx), 64'(exp_cnt));
            chk(bank_wdata == {vec_num, ctx_in}, "R4 bank data",
                bank_wdata[VW+NCTX*32-1 -: 64], 64'({vec_num, ctx_in[NCTX*32-1 -: 56]}));
        end
        chk(ovf_exc == ovf, "R7 overflow pulse", 64'(ovf_exc), 64'(ovf));
        chk(mask_we == setm, "R8 mask strobe", 64'(mask_we), 64'(setm));
        if (setm) chk(mask_val == 4'(lvl), "R8 mask value", 64'(mask_val), 64'(lvl));
        chk(sp_out == sp0 - 32'(4 * n), "R2 final sp", 64'(sp_out), 64'(sp0 - 32'(4 * n)));
        if (use_bank) exp_cnt++;
        @(negedge clk);
        chk(busy == 1'b0 && save_done == 1'b0, "R9 idle after done", 64'(busy), 64'd0);
        chk(bank_cnt == CW'(exp_cnt), "R5 bank count", 64'(bank_cnt), 64'(exp_cnt));
        chk(bank_full == (exp_cnt == NB), "R10 full flag", 64'(bank_full), 64'(exp_cnt == NB));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !bank_we && !save_done && !ovf_exc && !mask_we,
            "R1 reset strobes", 64'({busy, mem_we, bank_we, save_done, ovf_exc, mask_we}), 64'd0);
        chk(bank_cnt == 0 && !bank_full, "R1 reset bank count", 64'(bank_cnt), 64'd0);
        chk(sp_out == 32'd0, "R1 reset sp", 64'(sp_out), 64'd0);
        for (int kind = 0; kind < 6; kind++)
            for (int b = 0; b < 2; b++)
                for (int o = 0; o < 2; o++)
                    run_exc(kind, (kind * 4 + b * 2 + o) % 16, 16 + kind * 4 + b * 2 + o,
                            1'(b), 1'(o), 1'b0);
        while (exp_cnt < NB) run_exc(0, exp_cnt % 16, 64 + exp_cnt, 1'b1, 1'(exp_cnt % 2), 1'b0);
        chk(bank_cnt == CW'(NB), "R10 saturated count", 64'(bank_cnt), 64'(NB));
        for (int kind = 0; kind < 6; kind++)
            for (int b = 0; b < 2; b++)
                for (int o = 0; o < 2; o++)
                    run_exc(kind, 15 - kind, 128 + kind * 4 + b * 2 + o, 1'(b), 1'(o),
                            (kind == 0 && b == 1 && o == 0));
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule